// File: doc/BRIEF.md
# Segmented Logical Address Translator

This block turns a 32-bit system or debug address plus a requested transfer length into a location in one of three physical memory spaces (unified, on-chip instruction, on-chip data), together with the number of bytes that can move before a segment or block boundary is reached. The top address byte picks the route. Three codes select a physical space directly. Two codes select a logical space, which is remapped through a small bank of 16-bit map registers inside the block. A result whose length would be zero is reported as a fault.

Two banks of map registers exist: instruction maps and data maps. Each map register carries a target-space field and a segment number. The last data-map slot is special: it always points into data I/O space and picks a 4-bit page number per 4 KiB sub-window. The map registers are loaded through a simple write port that decodes a 16-bit register address. A request is accepted in any cycle and its result is registered one cycle later. The memory arrays themselves are outside this block.

Top module: `seg_addr_xlat`

## Requirements
- R1: After reset `rsp_valid` is 0 and every map register is 0, so a logical address resolves to unified space with segment 0 (data: physical = in-block offset; instruction: physical = in-block offset).
- R2: Bits 31:24 of `req_addr` select the route: 0x00 unified, 0x01 instruction, 0x02 data (all direct, physical = bits 23:0), 0x10 logical data, 0x11 logical instruction; any other value gives `rsp_fault`=1 with length 0.
- R3: A direct access is clipped so that (offset mod 64 KiB) + length never exceeds 64 KiB.
- R4: A logical offset (bits 23:0) is split into slot = offset / block size and in-block offset = offset mod block size (16 KiB data blocks, 4 data slots; 128 KiB instruction blocks, 2 instruction slots); an offset at or beyond slots × block size faults.
- R5: A data map (other than the last slot) uses bits 13:12 as target space and bits 9:0 as segment: 00 gives unified at seg×16 KiB + in-block offset, 01 gives instruction at seg×16 KiB + in-block offset, 10 gives data at (seg<<16) + slot×16 KiB + in-block offset, 11 faults; other bits are ignored.
- R6: The last data-map slot (slot 3) always targets data space: with sub = (in-block offset / 0x1000) mod 4, page = map bits [4(3−sub)+3 : 4(3−sub)], physical = page×0x10000 + 0xC000 + in-block offset.
- R7: An instruction map uses bits 13:12 as target space and bits 6:0 as segment: 00 gives unified at (seg<<17) + in-block offset, 01 gives instruction at slot×128 KiB + in-block offset, 10 faults; other bits are ignored.
- R8: Instruction-map space 11 is a test window: physical instruction address = in-block offset mod 0x800, and the length is also clipped so it never passes 0x800.
- R9: Every logical result is clipped at the map block boundary; the returned length never exceeds the requested one.
- R10: With `map_wr_en`=1, address 0xFF00 + 2i loads instruction map i, 0xFF08 + 2j loads data map j, and 0xFF04 also loads data map 2; a write to any other address changes no map.
- R11: The result of a request appears on the outputs exactly one cycle later; a map write in the same cycle as a request affects only later requests.
- R12: `rsp_fault` is 1 exactly when the returned length is 0, including a zero-length request; on a fault `rsp_space` is 3 and `rsp_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_addr | input | 16 | Map register address |
| map_wr_data | input | 16 | Map register write value |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Address to translate |
| req_len | input | 16 | Requested byte count |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_space | output | 2 | Target space: 0 unified, 1 instruction, 2 data, 3 none (fault) |
| rsp_addr | output | 32 | Physical address inside the target space |
| rsp_len | output | 16 | Clipped byte count |
| rsp_fault | output | 1 | Translation refused, length is zero |

## Verification
A map register holding a wrong value shows up on the very first logical request that uses that slot, one cycle later, as a wrong space code or a shifted physical address; slots not yet used hide it, so each slot is loaded and then read back through a translation. A broken address decode for writes shows as an unchanged mapping or as a neighbouring slot changing, which is why the alias and ignored addresses are followed by translations through the slots they might hit. Clipping faults appear only near a boundary, so requests are placed a few bytes before segment, block and test-window edges.

// File: rtl/seg_xlat_pkg.sv
// Shared types and helpers for the segmented address translator.
// Assumes map registers are 16 bits wide with fixed field positions.
package seg_xlat_pkg;

    localparam int MAP_W = 16;

    // Target memory space codes as seen on the response port.
    typedef enum logic [1:0] {
        SP_UNI  = 2'd0,
        SP_INS  = 2'd1,
        SP_DAT  = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    // Route codes carried in the top address byte.
    localparam logic [7:0] RT_PHY_UNI = 8'h00;
    localparam logic [7:0] RT_PHY_INS = 8'h01;
    localparam logic [7:0] RT_PHY_DAT = 8'h02;
    localparam logic [7:0] RT_LOG_DAT = 8'h10;
    localparam logic [7:0] RT_LOG_INS = 8'h11;

    // Smaller of two byte counts.
    function automatic logic [32:0] min33(input logic [32:0] a, input logic [32:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_xlat_maps.sv
// Map register bank: instruction maps and data maps behind a 16-bit
// register-address write port. One extra address aliases a data slot.
// Assumes the alias address does not coincide with any regular slot.
module seg_xlat_maps
    import seg_xlat_pkg::*;
#(
    parameter int N_IMAP     = 2,
    parameter int N_DMAP     = 4,
    parameter int CFG_AW     = 16,
    parameter int IMAP_BASE  = 'hFF00,
    parameter int DMAP_BASE  = 'hFF08,
    parameter int ALIAS_ADDR = 'hFF04,
    parameter int ALIAS_SLOT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [MAP_W-1:0]  wr_data,
    output logic [MAP_W-1:0]  imap_q [N_IMAP],
    output logic [MAP_W-1:0]  dmap_q [N_DMAP]
);

    genvar gi;

    generate
        for (gi = 0; gi < N_IMAP; gi++) begin : g_imap
            localparam logic [CFG_AW-1:0] SLOT_ADDR = CFG_AW'(IMAP_BASE + 2 * gi);
            logic hit;
            assign hit = wr_en && (wr_addr == SLOT_ADDR);

            // Load instruction map slot on an address match.
            always_ff @(posedge clk) begin
                if (!rst_n)   imap_q[gi] <= '0;
                else if (hit) imap_q[gi] <= wr_data;
            end

            p_imap_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == SLOT_ADDR) |=> (imap_q[gi] == $past(wr_data)))
                else $error("instruction map slot not loaded");
        end

        for (gi = 0; gi < N_DMAP; gi++) begin : g_dmap
            localparam logic [CFG_AW-1:0] SLOT_ADDR = CFG_AW'(DMAP_BASE + 2 * gi);
            localparam bit HAS_ALIAS = (gi == ALIAS_SLOT);
            logic hit;
            assign hit = wr_en && ((wr_addr == SLOT_ADDR) ||
                                   (HAS_ALIAS && (wr_addr == CFG_AW'(ALIAS_ADDR))));

            // Load data map slot on a regular or alias address match.
            always_ff @(posedge clk) begin
                if (!rst_n)   dmap_q[gi] <= '0;
                else if (hit) dmap_q[gi] <= wr_data;
            end

            p_dmap_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == SLOT_ADDR) |=> (dmap_q[gi] == $past(wr_data)))
                else $error("data map slot not loaded");

            if (HAS_ALIAS) begin : g_alias
                p_alias_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && wr_addr == CFG_AW'(ALIAS_ADDR)) |=> (dmap_q[gi] == $past(wr_data)))
                    else $error("alias write missed its data slot");
            end
        end
    endgenerate

endmodule

// File: rtl/seg_xlat_dmap.sv
// Logical data-space translation through the data map bank.
// Combinational. The last slot is the I/O window with per-4KiB pages.
// Assumes DBLK_W >= 14 so four 4 KiB sub-windows fit in a block.
module seg_xlat_dmap
    import seg_xlat_pkg::*;
#(
    parameter int N_DMAP = 4,
    parameter int DBLK_W = 14,
    parameter int LEN_W  = 16,
    parameter int OFF_W  = 24
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    input  logic [MAP_W-1:0] maps [N_DMAP],
    output logic             fault,
    output space_e           space,
    output logic [31:0]      addr,
    output logic [LEN_W-1:0] len_o
);

    localparam int          IDX_W   = (N_DMAP > 1) ? $clog2(N_DMAP) : 1;
    localparam int          IO_SLOT = N_DMAP - 1;
    localparam logic [32:0] BLK     = 33'(1) << DBLK_W;
    localparam logic [32:0] SPAN    = 33'(N_DMAP) << DBLK_W;

    logic [32:0]      woff;
    logic [32:0]      boff;
    logic [32:0]      room;
    logic [IDX_W-1:0] idx;
    logic [MAP_W-1:0] m;
    logic [1:0]       sub;
    logic [3:0]       page;
    logic [9:0]       seg;

    // Split the offset, select the map and form the physical location.
    always_comb begin
        woff  = 33'(off);
        boff  = woff & (BLK - 33'd1);
        room  = BLK - boff;
        idx   = IDX_W'(woff >> DBLK_W);
        m     = maps[idx];
        seg   = m[9:0];
        sub   = 2'(boff >> 12);
        page  = 4'(m >> {~sub, 2'b00});
        fault = 1'b0;
        space = SP_UNI;
        addr  = '0;
        len_o = LEN_W'(min33(33'(len), room));
        if (woff >= SPAN) begin
            fault = 1'b1;
        end else if (int'(idx) == IO_SLOT) begin
            space = SP_DAT;
            addr  = (32'(page) << 16) + 32'h0000_C000 + 32'(boff);
        end else begin
            case (m[13:12])
                2'b00: begin
                    space = SP_UNI;
                    addr  = (32'(seg) << DBLK_W) + 32'(boff);
                end
                2'b01: begin
                    space = SP_INS;
                    addr  = (32'(seg) << DBLK_W) + 32'(boff);
                end
                2'b10: begin
                    space = SP_DAT;
                    addr  = (32'(seg) << 16) + (32'(idx) << DBLK_W) + 32'(boff);
                end
                default: fault = 1'b1;
            endcase
        end
        if (fault) begin
            space = SP_NONE;
            addr  = '0;
            len_o = '0;
        end
    end

endmodule

// File: rtl/seg_xlat_imap.sv
// Logical instruction-space translation through the instruction maps.
// Combinational. Space 11 is a small wrapping test window.
// Assumes IBLK_W > TWIN_W.
module seg_xlat_imap
    import seg_xlat_pkg::*;
#(
    parameter int N_IMAP = 2,
    parameter int IBLK_W = 17,
    parameter int TWIN_W = 11,
    parameter int LEN_W  = 16,
    parameter int OFF_W  = 24
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    input  logic [MAP_W-1:0] maps [N_IMAP],
    output logic             fault,
    output space_e           space,
    output logic [31:0]      addr,
    output logic [LEN_W-1:0] len_o
);

    localparam int          IDX_W = (N_IMAP > 1) ? $clog2(N_IMAP) : 1;
    localparam logic [32:0] BLK   = 33'(1) << IBLK_W;
    localparam logic [32:0] SPAN  = 33'(N_IMAP) << IBLK_W;
    localparam logic [32:0] TWIN  = 33'(1) << TWIN_W;

    logic [32:0]      woff;
    logic [32:0]      boff;
    logic [32:0]      toff;
    logic [32:0]      keep;
    logic [IDX_W-1:0] idx;
    logic [MAP_W-1:0] m;
    logic             unused_imap;

    assign unused_imap = ^{m[15:14], m[11:7]};

    // Split the offset, select the map and form the physical location.
    always_comb begin
        woff  = 33'(off);
        boff  = woff & (BLK - 33'd1);
        toff  = boff & (TWIN - 33'd1);
        keep  = min33(33'(len), BLK - boff);
        idx   = IDX_W'(woff >> IBLK_W);
        m     = maps[idx];
        fault = 1'b0;
        space = SP_UNI;
        addr  = '0;
        if (woff >= SPAN) begin
            fault = 1'b1;
        end else begin
            case (m[13:12])
                2'b00: begin
                    space = SP_UNI;
                    addr  = (32'(m[6:0]) << IBLK_W) + 32'(boff);
                end
                2'b01: begin
                    space = SP_INS;
                    addr  = (32'(idx) << IBLK_W) + 32'(boff);
                end
                2'b11: begin
                    space = SP_INS;
                    addr  = 32'(toff);
                    keep  = min33(keep, TWIN - toff);
                end
                default: fault = 1'b1;
            endcase
        end
        len_o = LEN_W'(keep);
        if (fault) begin
            space = SP_NONE;
            addr  = '0;
            len_o = '0;
        end
    end

endmodule

// File: rtl/seg_addr_xlat.sv
// Segmented address translator top: decodes the route byte, clips direct
// accesses at the segment size, hands logical accesses to the map units
// and registers the result one cycle after the request.
// Assumes SEG_W <= 24 (segments fit inside the 24-bit offset).
module seg_addr_xlat
    import seg_xlat_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int N_IMAP = 2,
    parameter int N_DMAP = 4,
    parameter int DBLK_W = 14,
    parameter int IBLK_W = 17,
    parameter int SEG_W  = 16,
    parameter int TWIN_W = 11,
    parameter int CFG_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_wr_en,
    input  logic [CFG_AW-1:0] map_wr_addr,
    input  logic [MAP_W-1:0]  map_wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic [1:0]        rsp_space,
    output logic [31:0]       rsp_addr,
    output logic [LEN_W-1:0]  rsp_len,
    output logic              rsp_fault
);

    localparam int          OFF_W = 24;
    localparam logic [32:0] SEG   = 33'(1) << SEG_W;

    logic [MAP_W-1:0] imap_q [N_IMAP];
    logic [MAP_W-1:0] dmap_q [N_DMAP];

    logic [7:0]       route;
    logic [OFF_W-1:0] off;

    logic             d_fault, i_fault;
    space_e           d_space, i_space;
    logic [31:0]      d_addr,  i_addr;
    logic [LEN_W-1:0] d_len,   i_len;

    logic             nx_fault;
    space_e           nx_space;
    logic [31:0]      nx_addr;
    logic [LEN_W-1:0] nx_len;

    assign route = req_addr[31:24];
    assign off   = req_addr[OFF_W-1:0];

    seg_xlat_maps #(
        .N_IMAP (N_IMAP),
        .N_DMAP (N_DMAP),
        .CFG_AW (CFG_AW)
    ) u_maps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr_en),
        .wr_addr (map_wr_addr),
        .wr_data (map_wr_data),
        .imap_q  (imap_q),
        .dmap_q  (dmap_q)
    );

    seg_xlat_dmap #(
        .N_DMAP (N_DMAP),
        .DBLK_W (DBLK_W),
        .LEN_W  (LEN_W),
        .OFF_W  (OFF_W)
    ) u_dmap (
        .off   (off),
        .len   (req_len),
        .maps  (dmap_q),
        .fault (d_fault),
        .space (d_space),
        .addr  (d_addr),
        .len_o (d_len)
    );

    seg_xlat_imap #(
        .N_IMAP (N_IMAP),
        .IBLK_W (IBLK_W),
        .TWIN_W (TWIN_W),
        .LEN_W  (LEN_W),
        .OFF_W  (OFF_W)
    ) u_imap (
        .off   (off),
        .len   (req_len),
        .maps  (imap_q),
        .fault (i_fault),
        .space (i_space),
        .addr  (i_addr),
        .len_o (i_len)
    );

    // Route select, direct-space clipping and zero-length fault folding.
    always_comb begin
        nx_fault = 1'b0;
        nx_space = SP_NONE;
        nx_addr  = '0;
        nx_len   = '0;
        case (route)
            RT_PHY_UNI, RT_PHY_INS, RT_PHY_DAT: begin
                nx_space = space_e'(route[1:0]);
                nx_addr  = 32'(off);
                nx_len   = LEN_W'(min33(33'(req_len), SEG - (33'(off) & (SEG - 33'd1))));
            end
            RT_LOG_DAT: begin
                nx_fault = d_fault;
                nx_space = d_space;
                nx_addr  = d_addr;
                nx_len   = d_len;
            end
            RT_LOG_INS: begin
                nx_fault = i_fault;
                nx_space = i_space;
                nx_addr  = i_addr;
                nx_len   = i_len;
            end
            default: nx_fault = 1'b1;
        endcase
        if (nx_len == '0) nx_fault = 1'b1;
        if (nx_fault) begin
            nx_space = SP_NONE;
            nx_addr  = '0;
            nx_len   = '0;
        end
    end

    // Result register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_space <= SP_NONE;
            rsp_addr  <= '0;
            rsp_len   <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_space <= nx_space;
            rsp_addr  <= nx_addr;
            rsp_len   <= nx_len;
            rsp_fault <= nx_fault;
        end
    end

    p_fault_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_len == '0)))
        else $error("fault flag and length disagree");

    p_len_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_len <= $past(req_len)))
        else $error("returned length exceeds request");

    p_bad_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && route != RT_PHY_UNI && route != RT_PHY_INS && route != RT_PHY_DAT &&
         route != RT_LOG_DAT && route != RT_LOG_INS) |=> rsp_fault)
        else $error("unknown route did not fault");

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)))
        else $error("response not one cycle after request");

    p_direct_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (route == RT_PHY_UNI || route == RT_PHY_INS || route == RT_PHY_DAT))
        |=> ((33'(rsp_addr) & (SEG - 33'd1)) + 33'(rsp_len) <= SEG))
        else $error("direct access crosses a segment");

endmodule

// File: tb/test_seg_addr_xlat.sv
module test_seg_addr_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_wr_en = 1'b0;
    logic [15:0] map_wr_addr = '0;
    logic [15:0] map_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_space;
    logic [31:0] rsp_addr;
    logic [15:0] rsp_len;
    logic        rsp_fault;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [1:0] S_UNI = 2'd0, S_INS = 2'd1, S_DAT = 2'd2, S_NONE = 2'd3;

    always #5 clk = ~clk;

    seg_addr_xlat i_seg_addr_xlat (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_wr_en   (map_wr_en),
        .map_wr_addr (map_wr_addr),
        .map_wr_data (map_wr_data),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .rsp_valid   (rsp_valid),
        .rsp_space   (rsp_space),
        .rsp_addr    (rsp_addr),
        .rsp_len     (rsp_len),
        .rsp_fault   (rsp_fault)
    );

    task automatic map_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_addr = a; map_wr_data = d;
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    task automatic run_xlat(input logic [31:0] a, input logic [15:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_ok(input string tag, input logic [1:0] sp,
                             input logic [31:0] ad, input logic [15:0] ln);
        n_cmp++;
        if (!rsp_valid || rsp_fault || rsp_space !== sp || rsp_addr !== ad || rsp_len !== ln) begin
            n_bad++;
            $display("FAIL %s: got v=%0b f=%0b sp=%0d addr=%h len=%h, want v=1 f=0 sp=%0d addr=%h len=%h",
                     tag, rsp_valid, rsp_fault, rsp_space, rsp_addr, rsp_len, sp, ad, ln);
        end
    endtask

    task automatic expect_fault(input string tag);
        n_cmp++;
        if (!rsp_valid || !rsp_fault || rsp_len !== 16'd0 || rsp_space !== S_NONE || rsp_addr !== 32'd0) begin
            n_bad++;
            $display("FAIL %s: got v=%0b f=%0b sp=%0d addr=%h len=%h, want v=1 f=1 sp=3 addr=0 len=0",
                     tag, rsp_valid, rsp_fault, rsp_space, rsp_addr, rsp_len);
        end
    endtask

    task automatic t_reset;
        n_cmp++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: rsp_valid=%0b expected 0", rsp_valid);
        end
        run_xlat(32'h1000_1234, 16'd4);
        expect_ok("R1 data map zero", S_UNI, 32'h0000_1234, 16'd4);
        run_xlat(32'h1100_0200, 16'd4);
        expect_ok("R1 instr map zero", S_UNI, 32'h0000_0200, 16'd4);
    endtask

    task automatic t_direct;
        run_xlat(32'h0001_2345, 16'd8);
        expect_ok("R2 direct unified", S_UNI, 32'h0001_2345, 16'd8);
        run_xlat(32'h02AB_CDEF, 16'h0100);
        expect_ok("R2 direct data", S_DAT, 32'h00AB_CDEF, 16'h0100);
        run_xlat(32'h0100_FFFC, 16'd16);
        expect_ok("R3 direct instr clip", S_INS, 32'h0000_FFFC, 16'd4);
        run_xlat(32'h0500_0000, 16'd4);
        expect_fault("R2 route 0x05");
        run_xlat(32'h1234_0000, 16'd4);
        expect_fault("R2 route 0x12");
    endtask

    task automatic t_zero_len;
        run_xlat(32'h0000_0010, 16'd0);
        expect_fault("R12 zero length");
    endtask

    task automatic t_data_maps;
        map_write(16'hFF0A, 16'h1005);
        run_xlat(32'h1000_4010, 16'd4);
        expect_ok("R5 data map instr", S_INS, 32'h0001_4010, 16'd4);
        map_write(16'hFF08, 16'h2003);
        run_xlat(32'h1000_0100, 16'd2);
        expect_ok("R5 data map data", S_DAT, 32'h0003_0100, 16'd2);
        map_write(16'hFF08, 16'h3000);
        run_xlat(32'h1000_0100, 16'd2);
        expect_fault("R5 data map reserved");
        map_write(16'hFF08, 16'h0C01);
        run_xlat(32'h1000_0020, 16'd1);
        expect_ok("R5 data map ignores bits 11:10", S_UNI, 32'h0000_4020, 16'd1);
        map_write(16'hFF08, 16'h0201);
        run_xlat(32'h1000_0020, 16'd1);
        expect_ok("R5 data map wide segment", S_UNI, 32'h0080_4020, 16'd1);
        map_write(16'hFF08, 16'h0C01);
        run_xlat(32'h1001_0000, 16'd4);
        expect_fault("R4 data offset beyond range");
        run_xlat(32'h1000_3FF0, 16'h0040);
        expect_ok("R9 data block clip", S_UNI, 32'h0000_7FF0, 16'h0010);
    endtask

    task automatic t_alias_and_ignore;
        map_write(16'hFF04, 16'h2002);
        run_xlat(32'h1000_8040, 16'd4);
        expect_ok("R10 alias to data slot 2", S_DAT, 32'h0002_8040, 16'd4);
        map_write(16'hFF10, 16'h1FFF);
        map_write(16'hFF09, 16'h3000);
        run_xlat(32'h1000_8040, 16'd4);
        expect_ok("R10 ignored write slot 2", S_DAT, 32'h0002_8040, 16'd4);
        run_xlat(32'h1000_0020, 16'd1);
        expect_ok("R10 ignored write slot 0", S_UNI, 32'h0000_4020, 16'd1);
    endtask

    task automatic t_io_slot;
        map_write(16'hFF0E, 16'h1234);
        run_xlat(32'h1000_C010, 16'd4);
        expect_ok("R6 io sub 0", S_DAT, 32'h0001_C010, 16'd4);
        run_xlat(32'h1000_F004, 16'd4);
        expect_ok("R6 io sub 3", S_DAT, 32'h0004_F004, 16'd4);
        run_xlat(32'h1000_D100, 16'd4);
        expect_ok("R6 io sub 1", S_DAT, 32'h0002_D100, 16'd4);
    endtask

    task automatic t_instr_maps;
        map_write(16'hFF00, 16'h0085);
        run_xlat(32'h1100_0100, 16'd4);
        expect_ok("R7 instr map unified", S_UNI, 32'h000A_0100, 16'd4);
        map_write(16'hFF02, 16'h1000);
        run_xlat(32'h1102_0008, 16'd2);
        expect_ok("R7 instr map instr", S_INS, 32'h0002_0008, 16'd2);
        run_xlat(32'h1103_FFFE, 16'd8);
        expect_ok("R9 instr block clip", S_INS, 32'h0003_FFFE, 16'd2);
        map_write(16'hFF02, 16'h2000);
        run_xlat(32'h1102_0008, 16'd2);
        expect_fault("R7 instr map reserved");
        run_xlat(32'h1104_0000, 16'd4);
        expect_fault("R4 instr offset beyond range");
    endtask

    task automatic t_test_window;
        map_write(16'hFF00, 16'h3000);
        run_xlat(32'h1100_1830, 16'h0900);
        expect_ok("R8 test window wrap and clip", S_INS, 32'h0000_0030, 16'h07D0);
        run_xlat(32'h1100_0010, 16'd4);
        expect_ok("R8 test window short", S_INS, 32'h0000_0010, 16'd4);
    endtask

    task automatic t_timing;
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_addr = 16'hFF08; map_wr_data = 16'h1007;
        req_valid = 1'b1; req_addr = 32'h1000_0000; req_len = 16'd4;
        @(negedge clk);
        map_wr_en = 1'b0; req_valid = 1'b0;
        expect_ok("R11 same-cycle write uses old map", S_UNI, 32'h0000_4000, 16'd4);
        run_xlat(32'h1000_0000, 16'd4);
        expect_ok("R11 next request uses new map", S_INS, 32'h0001_C000, 16'd4);
        @(negedge clk);
        n_cmp++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 valid drop: rsp_valid=%0b expected 0", rsp_valid);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_zero_len();
        t_data_maps();
        t_alias_and_ignore();
        t_io_slot();
        t_instr_maps();
        t_test_window();
        t_timing();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule